// File: doc/BRIEF.md
# Pipelined Wallace carry-save summer

This block adds twelve unsigned operands of a parameterised width and returns their exact sum. Every operand is zero-extended to the result width, then the set is reduced to two vectors by layers of carry-save adders. Each bit cell of a layer is a full adder with no carry link to its neighbour. A single carry-propagate adder combines the last two vectors, and the result is held in an output register.

The reduction follows the largest-count-per-level sequence 2, 3, 4, 6, 9, 13, 19, 28. Each term is the floor of 3/2 times the previous one. The top layer uses only enough adders to reach the nearest smaller term, so twelve operands pass through counts 12, 9, 6, 4, 3, 2 in five layers. A parameter places a pipeline register after every layer or after every second layer. A valid flag travels beside the data with the same delay. There is no backpressure, so a new operand set may be offered on every clock.

Top module: `wallaceSumPipe`

## Requirements
- R1: For each accepted set, `sumOut` equals the exact unsigned sum of the twelve `WIDTH`-bit fields of `operands`. Field i is `operands[i*WIDTH +: WIDTH]`, and the result is `WIDTH+4` bits wide.
- R2: With `REG_EVERY = 1` the reduction takes five carry-save layers, each followed by a register. `validOut` and the matching sum therefore appear on the sixth rising edge after the edge that samples `validIn` high.
- R3: With `REG_EVERY = 2` registers follow layers two and four only. The result appears on the third rising edge after the sampling edge.
- R4: A set is accepted on every edge where `validIn` is high, including back-to-back edges. Each accepted set yields exactly one `validOut` pulse, in acceptance order, and `validOut` never rises without an accepted set in flight.
- R5: While `validOut` is low, `sumOut` keeps the last result it delivered.
- R6: While `rstN` is low, `validOut` is 0 and `sumOut` is 0. The reset is asynchronous and active low.
- R7: The largest possible sum, 12 x (2^WIDTH - 1) = 3060 for WIDTH = 8, is delivered without overflow, and `sumOut` never exceeds that bound.
- R8: Carry vectors are weighted one bit above their sum vectors, and carries that leave the operand width land in the extension bits. For example, twelve operands of 0x80 give 1536.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| validIn | input | 1 | Operand set on `operands` is valid this cycle |
| operands | input | NUM_OPS*WIDTH | Twelve packed unsigned operands, operand i in bits i*WIDTH upward |
| validOut | output | 1 | `sumOut` carries a new result this cycle |
| sumOut | output | WIDTH+$clog2(NUM_OPS) | Full-precision sum |

## Verification
A misrouted carry or a wrong pass-through slot in any layer corrupts only the sums whose operands produce carries at that bit. Such faults show up as wrong totals on the first dense pattern, such as all ones or all 0x80, one pipeline latency after it is offered. A strobe routed to the wrong stage register passes isolated sets but scrambles back-to-back streams, so random sets are streamed without gaps as well as with them. A shortened or lengthened valid chain moves the first `validOut` pulse by whole cycles, and each result's arrival cycle is compared against the expected latency. Both pipelining choices run side by side on the same stimulus.

// File: rtl/wtPkg.sv
package wtPkg;

  localparam int MAX_STAGES = 16;

  typedef struct packed {
    logic [MAX_STAGES-1:0] stageLoad;
    logic                  outLoad;
  } ctrlStrobes_t;

  // largest member of 2,3,4,6,9,13,... strictly below k (k > 2)
  function automatic int seqBelow(input int k);
    int s;
    s = 2;
    for (int i = 0; i < 64; i++) begin
      if ((3 * s) / 2 < k) s = (3 * s) / 2;
    end
    return s;
  endfunction

  // operand count present after a given number of layers
  function automatic int countAt(input int k, input int lvl);
    int c;
    c = k;
    for (int i = 0; i < 64; i++) begin
      if (i < lvl && c > 2) c = seqBelow(c);
    end
    return c;
  endfunction

  function automatic int numLevels(input int k);
    int c;
    int n;
    c = k;
    n = 0;
    for (int i = 0; i < 64; i++) begin
      if (c > 2) begin
        c = seqBelow(c);
        n = n + 1;
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/wtCsaLevel.sv
module wtCsaLevel #(
  parameter int RW        = 12,
  parameter int IN_COUNT  = 12,
  parameter int OUT_COUNT = 9
) (
  input  logic [IN_COUNT-1:0][RW-1:0]  inVec,
  output logic [OUT_COUNT-1:0][RW-1:0] outVec
);

  localparam int NUM_CSA = IN_COUNT - OUT_COUNT;

  // full adders in groups of three, carry moved up one weight
  for (genvar g = 0; g < NUM_CSA; g++) begin : gCsa
    logic [RW-1:0] a, b, c;
    logic [RW-2:0] cy;
    assign a  = inVec[3*g];
    assign b  = inVec[3*g+1];
    assign c  = inVec[3*g+2];
    assign cy = (a[RW-2:0] & b[RW-2:0]) | (a[RW-2:0] & c[RW-2:0]) |
                (b[RW-2:0] & c[RW-2:0]);
    assign outVec[2*g]   = a ^ b ^ c;
    assign outVec[2*g+1] = {cy, 1'b0};
  end

  // operands left over travel to the next layer untouched
  for (genvar p = 3*NUM_CSA; p < IN_COUNT; p++) begin : gPass
    assign outVec[p-NUM_CSA] = inVec[p];
  end

endmodule

// File: rtl/wtControl.sv
module wtControl
  import wtPkg::*;
#(
  parameter int NUM_OPS   = 12,
  parameter int REG_EVERY = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         validIn,
  output ctrlStrobes_t strobes,
  output logic         validOut
);

  localparam int NL  = numLevels(NUM_OPS);
  localparam int NR  = NL / REG_EVERY;
  localparam int LAT = NR + 1;

  logic [LAT:1] validPipe;
  logic [LAT:0] validChain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validPipe <= '0;
    end else begin
      validPipe[1] <= validIn;
      for (int i = 2; i <= LAT; i++) validPipe[i] <= validPipe[i-1];
    end
  end

  assign validChain = {validPipe, validIn};

  always_comb begin
    strobes = '0;
    for (int s = 0; s < NR; s++) strobes.stageLoad[s] = validChain[s];
    strobes.outLoad = validChain[NR];
  end

  assign validOut = validChain[LAT];

endmodule

// File: rtl/wtDatapath.sv
module wtDatapath
  import wtPkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int NUM_OPS   = 12,
  parameter int REG_EVERY = 1
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic [NUM_OPS*WIDTH-1:0]               operands,
  input  ctrlStrobes_t                           strobes,
  output logic [WIDTH+$clog2(NUM_OPS)-1:0]       sumOut
);

  localparam int RW = WIDTH + $clog2(NUM_OPS);
  localparam int NL = numLevels(NUM_OPS);

  logic          unusedLoads;
  logic [RW-1:0] cpaSum;
  logic [RW-1:0] sumQ;

  assign unusedLoads = ^strobes.stageLoad;

  for (genvar l = 0; l <= NL; l++) begin : lvlGen
    localparam int CNT = countAt(NUM_OPS, l);
    logic [CNT-1:0][RW-1:0] stageQ;

    if (l == 0) begin : gIn
      for (genvar i = 0; i < NUM_OPS; i++) begin : gExt
        assign stageQ[i] = {{(RW-WIDTH){1'b0}}, operands[i*WIDTH +: WIDTH]};
      end
    end else begin : gRed
      localparam int PREV = countAt(NUM_OPS, l-1);
      logic [CNT-1:0][RW-1:0] combQ;

      wtCsaLevel #(
        .RW(RW), .IN_COUNT(PREV), .OUT_COUNT(CNT)
      ) uLevel (
        .inVec(lvlGen[l-1].stageQ),
        .outVec(combQ)
      );

      if ((l % REG_EVERY) == 0) begin : gReg
        always_ff @(posedge clk) begin
          if (strobes.stageLoad[l/REG_EVERY-1]) stageQ <= combQ;
        end
      end else begin : gWire
        assign stageQ = combQ;
      end
    end
  end

  // final carry-propagate adder on the two surviving vectors
  assign cpaSum = lvlGen[NL].stageQ[0] + lvlGen[NL].stageQ[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               sumQ <= '0;
    else if (strobes.outLoad) sumQ <= cpaSum;
  end

  assign sumOut = sumQ;

endmodule

// File: rtl/wallaceSumPipe.sv
module wallaceSumPipe
  import wtPkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int NUM_OPS   = 12,
  parameter int REG_EVERY = 1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             validIn,
  input  logic [NUM_OPS*WIDTH-1:0]         operands,
  output logic                             validOut,
  output logic [WIDTH+$clog2(NUM_OPS)-1:0] sumOut
);

  ctrlStrobes_t strobes;

  wtControl #(
    .NUM_OPS(NUM_OPS), .REG_EVERY(REG_EVERY)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .validIn(validIn),
    .strobes(strobes), .validOut(validOut)
  );

  wtDatapath #(
    .WIDTH(WIDTH), .NUM_OPS(NUM_OPS), .REG_EVERY(REG_EVERY)
  ) uData (
    .clk(clk), .rstN(rstN), .operands(operands),
    .strobes(strobes), .sumOut(sumOut)
  );

endmodule

// File: rtl/wallaceSumPipe_chk.sv
module wallaceSumPipe_chk
  import wtPkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int NUM_OPS   = 12,
  parameter int REG_EVERY = 1
) (
  input logic                             clk,
  input logic                             rstN,
  input logic                             validIn,
  input logic                             validOut,
  input logic [WIDTH+$clog2(NUM_OPS)-1:0] sumOut
);

  localparam int    LAT     = numLevels(NUM_OPS) / REG_EVERY + 1;
  localparam longint MAX_SUM = longint'(NUM_OPS) * ((longint'(1) << WIDTH) - 1);

  logic [7:0] inFlight;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inFlight <= '0;
    else       inFlight <= inFlight + 8'(validIn) - 8'(validOut);
  end

  AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    32'(inFlight) <= LAT);                                           // R4
  AST_OUT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> inFlight != 0);                                     // R4
  AST_VALID_KNOWN: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown(validOut));                                          // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !validOut |-> $stable(sumOut));                                  // R5
  AST_SUM_CEILING: assert property (@(posedge clk) disable iff (!rstN)
    64'(sumOut) <= 64'(MAX_SUM));                                    // R7

endmodule

bind wallaceSumPipe wallaceSumPipe_chk #(
  .WIDTH(WIDTH), .NUM_OPS(NUM_OPS), .REG_EVERY(REG_EVERY)
) uChk (
  .clk(clk), .rstN(rstN), .validIn(validIn),
  .validOut(validOut), .sumOut(sumOut)
);

// File: tb/tb_wallaceSumPipe.sv
`timescale 1ns/1ps
module tb_wallaceSumPipe;

  localparam int W   = 8;
  localparam int NOP = 12;
  localparam int RW  = 12;
  localparam int NT  = 8;
  localparam int LAT_A = 6;   // R2: five layers plus output register
  localparam int LAT_B = 3;   // R3: two tree registers plus output register

  localparam logic [NOP*W-1:0] STIM [NT] = '{
    {12{8'h00}},
    {12{8'hFF}},
    {12{8'h01}},
    {8'd11, 8'd10, 8'd9, 8'd8, 8'd7, 8'd6, 8'd5, 8'd4, 8'd3, 8'd2, 8'd1, 8'd0},
    {{11{8'h00}}, 8'h80},
    {6{8'hAA, 8'h55}},
    {12{8'h80}},
    {8'hFF, {11{8'h00}}}
  };
  localparam int EXPSUM [NT] = '{0, 3060, 12, 66, 128, 1530, 1536, 255};

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           validIn = 1'b0;
  logic [NOP*W-1:0] operands = '0;
  logic           vOutA, vOutB;
  logic [RW-1:0]  sOutA, sOutB;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int sent   = 0;
  int gotA   = 0;
  int gotB   = 0;
  int expQ [2][$];
  int tagQ [2][$];

  always #4 clk = ~clk;

  wallaceSumPipe #(.WIDTH(W), .NUM_OPS(NOP), .REG_EVERY(1)) dut (
    .clk(clk), .rstN(rstN), .validIn(validIn), .operands(operands),
    .validOut(vOutA), .sumOut(sOutA));

  wallaceSumPipe #(.WIDTH(W), .NUM_OPS(NOP), .REG_EVERY(2)) dutPair (
    .clk(clk), .rstN(rstN), .validIn(validIn), .operands(operands),
    .validOut(vOutB), .sumOut(sOutB));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      checks++;
      fails++;
      $display("FAIL R4 watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic monitor(input int d, input logic v, input logic [RW-1:0] s, input int lat);
    int e;
    int t;
    if (!v) return;
    if (expQ[d].size() == 0) begin
      check("R4 unexpected validOut", 1, 0);
      return;
    end
    e = expQ[d].pop_front();
    t = tagQ[d].pop_front();
    check("R1 sum", int'(s), e);
    check(d == 0 ? "R2 latency" : "R3 latency", cyc - t, lat);
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      monitor(0, vOutA, sOutA, LAT_A);
      monitor(1, vOutB, sOutB, LAT_B);
      if (vOutA) gotA++;
      if (vOutB) gotB++;
    end
  end

  function automatic int refSum(input logic [NOP*W-1:0] ops);
    int acc;
    acc = 0;
    for (int i = 0; i < NOP; i++) acc += int'(ops[i*W +: W]);
    return acc;
  endfunction

  task automatic offer(input logic [NOP*W-1:0] ops);
    @(negedge clk);
    operands = ops;
    validIn  = 1'b1;
    sent++;
    for (int d = 0; d < 2; d++) begin
      expQ[d].push_back(refSum(ops));
      tagQ[d].push_back(cyc);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      validIn = 1'b0;
    end
  endtask

  initial begin
    // R6: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R6 validOut in reset", int'(vOutA), 0);
      check("R6 sumOut in reset", int'(sOutA), 0);
      check("R6 validOut in reset pair", int'(vOutB), 0);
      check("R6 sumOut in reset pair", int'(sOutB), 0);
    end
    rstN = 1'b1;
    idle(2);

    // R1 R7 R8: table walked back to back, reference values checked too
    for (int t = 0; t < NT; t++) begin
      check("R1 table reference", refSum(STIM[t]), EXPSUM[t]);
      offer(STIM[t]);
    end
    idle(10);

    // R5: last table entry (255) held while idle
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R5 hold sum", int'(sOutA), 255);
      check("R5 hold sum pair", int'(sOutB), 255);
      check("R5 no valid while idle", int'(vOutA | vOutB), 0);
    end

    // R7 R8: isolated dense patterns with gaps
    offer({12{8'hFF}});
    idle(7);
    offer({12{8'h80}});
    idle(7);

    // R4: random sets, first back to back, then with gaps
    for (int n = 0; n < 300; n++) begin
      logic [NOP*W-1:0] r;
      for (int i = 0; i < NOP; i++) r[i*W +: W] = 8'($urandom);
      if (n < 150 || $urandom_range(3) != 0) offer(r);
      else idle(1);
    end
    idle(12);

    check("R4 one result per set", gotA, sent);
    check("R4 one result per set pair", gotB, sent);
    check("R4 nothing left in flight", expQ[0].size() + expQ[1].size(), 0);

    summary();
    $finish;
  end

endmodule